// File: doc/BRIEF.md
# Shadow Stack Sequencer

This block carries out the shadow-stack instructions of a processor core. These instructions protect function returns. The block owns the shadow stack pointer and takes one decoded operation at a time: push a return address, pop and verify it, copy the pointer out, or atomically swap a word or doubleword in shadow-stack memory. Each memory access goes out on a simple request/response port that marks the access as shadow-stack traffic. The block reports either a result for register writeback or an exception with a cause and a trap value.

The pipeline issues an operation while `busy` is low. Operations that need memory hold `busy` high until the response returns. The pointer moves only when a faultless push, or a matching pop, completes. Software may load the pointer through a write port while the unit is idle.

Top module: `sstk_unit`

## Requirements
- R1: The pointer step is 8 bytes when `wide_mode` is 1 and 4 bytes when it is 0. Push and pop accesses use that size (`mem_req_dw` = `wide_mode`).
- R2: Push (op 0) requests a store of `op_b` at pointer minus step, with `mem_req_we`=1 and `mem_req_ss`=1. On a good response the pointer becomes pointer minus step. Push produces no writeback.
- R3: Pop-and-check (op 1) requests a load at the pointer. When the returned data equals `op_a` the pointer becomes pointer plus step. In 4-byte mode only bits 31:0 are compared.
- R4: A pop mismatch raises cause 18 with tval 3 and leaves the pointer unchanged.
- R5: An access whose address is not a multiple of its size raises cause 6 with tval equal to the address. No memory request is made.
- R6: Read-pointer (op 2) writes the pointer to `wb_rd` one cycle after issue. With destination 0 it raises cause 2 with tval 0.
- R7: When `bcfi_en` is 0, ops 0, 1 and 2 raise cause 2. So do both swaps outside machine mode. Op codes 5 to 7 also raise cause 2.
- R8: A swap (op 3 word, op 4 doubleword) issued with `mach_mode`=1 raises cause 7 with tval equal to the address and makes no request.
- R9: A swap stores `op_b` at address `op_a` with `mem_req_swap`=1 and writes back the old value. The word form sign-extends bit 31. The doubleword form with `wide_mode`=0 raises cause 2.
- R10: A memory error response raises cause 7 with tval equal to the request address, even for a pop. The pointer is left unchanged.
- R11: `busy` stays high from issue of a memory operation until its response. Issues while `busy` is high are ignored.
- R12: `ssp_wr` loads `ssp_wdata` into the pointer when `busy` is low and is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low reset |
| issue_valid | input | 1 | operation presented |
| issue_op | input | 3 | 0 push, 1 pop-check, 2 read-ptr, 3 swap word, 4 swap dword |
| issue_rd | input | 5 | destination register index |
| op_a | input | XLEN | first source (pop compare value, swap address) |
| op_b | input | XLEN | second source (push/swap store data) |
| wide_mode | input | 1 | active register width is 64 bits |
| mach_mode | input | 1 | core is in machine mode |
| bcfi_en | input | 1 | return protection enabled for current mode |
| ssp_wr | input | 1 | software pointer write |
| ssp_wdata | input | XLEN | pointer write value |
| busy | output | 1 | memory operation in flight |
| mem_req_valid | output | 1 | memory request |
| mem_req_we | output | 1 | request writes |
| mem_req_swap | output | 1 | request is an atomic swap |
| mem_req_dw | output | 1 | 8-byte access (else 4-byte) |
| mem_req_ss | output | 1 | shadow-stack access tag |
| mem_req_addr | output | XLEN | request address |
| mem_req_wdata | output | XLEN | store data |
| mem_resp_valid | input | 1 | response present |
| mem_resp_err | input | 1 | response carries an access fault |
| mem_resp_rdata | input | XLEN | loaded or old data |
| wb_valid | output | 1 | writeback pulse |
| wb_rd | output | 5 | writeback register |
| wb_data | output | XLEN | writeback value |
| exc_valid | output | 1 | exception pulse |
| exc_cause | output | 5 | exception cause |
| exc_tval | output | XLEN | trap value / check code |

## Verification
A stale or wrongly stepped pointer surfaces at the very next push or pop. It shows as a wrong `mem_req_addr` in the cycle after issue. It also shows in the data of a read-pointer one cycle after issue. A pointer updated on a fault or mismatch shows in the following read-pointer. A stuck or early-cleared in-flight state shows either as a dropped response or as an issue accepted while `busy` was high. In the second case a writeback pulse appears where none should.

// File: rtl/sstk_unit.sv
module sstk_unit #(
  parameter int XLEN = 64,
  parameter logic [XLEN-1:0] SSP_RST = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [2:0]      issue_op,
  input  logic [4:0]      issue_rd,
  input  logic [XLEN-1:0] op_a,
  input  logic [XLEN-1:0] op_b,
  input  logic            wide_mode,
  input  logic            mach_mode,
  input  logic            bcfi_en,
  input  logic            ssp_wr,
  input  logic [XLEN-1:0] ssp_wdata,
  output logic            busy,
  output logic            mem_req_valid,
  output logic            mem_req_we,
  output logic            mem_req_swap,
  output logic            mem_req_dw,
  output logic            mem_req_ss,
  output logic [XLEN-1:0] mem_req_addr,
  output logic [XLEN-1:0] mem_req_wdata,
  input  logic            mem_resp_valid,
  input  logic            mem_resp_err,
  input  logic [XLEN-1:0] mem_resp_rdata,
  output logic            wb_valid,
  output logic [4:0]      wb_rd,
  output logic [XLEN-1:0] wb_data,
  output logic            exc_valid,
  output logic [4:0]      exc_cause,
  output logic [XLEN-1:0] exc_tval
);
  localparam logic [2:0] OP_PUSH = 3'd0, OP_POP = 3'd1, OP_RDP = 3'd2,
                         OP_SWW = 3'd3, OP_SWD = 3'd4;
  localparam logic [4:0] C_ILL = 5'd2, C_MISAL = 5'd6, C_ACC = 5'd7, C_SWCHK = 5'd18;
  localparam logic [XLEN-1:0] BCFI_CODE = XLEN'(3);

  logic            mem_q, dw_q, wide_q;
  logic [2:0]      op_q;
  logic [4:0]      rd_q;
  logic [XLEN-1:0] ssp_q, addr_q, data_q, nptr_q;

  logic [XLEN-1:0] step, acc_addr, f_tval, swap_ret;
  logic            is_swap, acc_dw, misal, f_hit, accept, resp_done, match, commit_ok;
  logic [4:0]      f_cause;

  assign step     = wide_mode ? XLEN'(8) : XLEN'(4);
  assign is_swap  = (issue_op == OP_SWW) || (issue_op == OP_SWD);
  assign acc_dw   = (issue_op == OP_SWD) || (!is_swap && wide_mode);
  assign acc_addr = (issue_op == OP_PUSH) ? ssp_q - step :
                    (issue_op == OP_POP)  ? ssp_q : op_a;
  assign misal    = acc_dw ? (acc_addr[2:0] != 3'd0) : (acc_addr[1:0] != 2'd0);
  assign accept   = issue_valid && !mem_q;

  always_comb begin
    f_hit   = 1'b1;
    f_cause = C_ILL;
    f_tval  = '0;
    if (issue_op > OP_SWD || (issue_op == OP_SWD && !wide_mode)) begin
      f_cause = C_ILL;
    end else if (is_swap && mach_mode) begin
      f_cause = C_ACC;
      f_tval  = acc_addr;
    end else if (!bcfi_en) begin
      f_cause = C_ILL;
    end else if (issue_op == OP_RDP && issue_rd == 5'd0) begin
      f_cause = C_ILL;
    end else if (issue_op != OP_RDP && misal) begin
      f_cause = C_MISAL;
      f_tval  = acc_addr;
    end else begin
      f_hit = 1'b0;
    end
  end

  assign resp_done = mem_q && mem_resp_valid;
  assign match     = wide_q ? (mem_resp_rdata == data_q) : (mem_resp_rdata[31:0] == data_q[31:0]);
  assign commit_ok = resp_done && !mem_resp_err && (op_q == OP_PUSH || (op_q == OP_POP && match));
  assign swap_ret  = dw_q ? mem_resp_rdata : {{(XLEN-32){mem_resp_rdata[31]}}, mem_resp_rdata[31:0]};

  assign busy          = mem_q;
  assign mem_req_valid = mem_q;
  assign mem_req_ss    = mem_q;
  assign mem_req_we    = mem_q && (op_q != OP_POP);
  assign mem_req_swap  = mem_q && (op_q == OP_SWW || op_q == OP_SWD);
  assign mem_req_dw    = dw_q;
  assign mem_req_addr  = addr_q;
  assign mem_req_wdata = data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= 1'b0; dw_q <= 1'b0; wide_q <= 1'b0;
      op_q <= '0; rd_q <= '0;
      ssp_q <= SSP_RST; addr_q <= '0; data_q <= '0; nptr_q <= '0;
      wb_valid <= 1'b0; wb_rd <= '0; wb_data <= '0;
      exc_valid <= 1'b0; exc_cause <= '0; exc_tval <= '0;
    end else begin
      wb_valid  <= 1'b0;
      exc_valid <= 1'b0;
      if (!mem_q) begin
        if (ssp_wr) ssp_q <= ssp_wdata;
        if (accept) begin
          if (f_hit) begin
            exc_valid <= 1'b1;
            exc_cause <= f_cause;
            exc_tval  <= f_tval;
          end else if (issue_op == OP_RDP) begin
            wb_valid <= 1'b1;
            wb_rd    <= issue_rd;
            wb_data  <= ssp_q;
          end else begin
            mem_q  <= 1'b1;
            op_q   <= issue_op;
            rd_q   <= issue_rd;
            dw_q   <= acc_dw;
            wide_q <= wide_mode;
            addr_q <= acc_addr;
            data_q <= (issue_op == OP_POP) ? op_a : op_b;
            nptr_q <= (issue_op == OP_PUSH) ? acc_addr : ssp_q + step;
          end
        end
      end else if (mem_resp_valid) begin
        mem_q <= 1'b0;
        if (mem_resp_err) begin
          exc_valid <= 1'b1;
          exc_cause <= C_ACC;
          exc_tval  <= addr_q;
        end else if (op_q == OP_PUSH) begin
          ssp_q <= nptr_q;
        end else if (op_q == OP_POP) begin
          if (match) ssp_q <= nptr_q;
          else begin
            exc_valid <= 1'b1;
            exc_cause <= C_SWCHK;
            exc_tval  <= BCFI_CODE;
          end
        end else begin
          wb_valid <= 1'b1;
          wb_rd    <= rd_q;
          wb_data  <= swap_ret;
        end
      end
    end
  end

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mem_resp_valid |=> busy);
  // R2
  push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && mem_req_we && !mem_req_swap |-> mem_req_addr == ssp_q - (mem_req_dw ? XLEN'(8) : XLEN'(4)));
  // R3
  pop_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_we |-> mem_req_addr == ssp_q);
  // R5
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_dw ? mem_req_addr[2:0] == 3'd0 : mem_req_addr[1:0] == 2'd0));
  // R10
  ptr_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ssp_q) |-> $past(commit_ok || (ssp_wr && !busy)));
  // R4
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wb_valid && exc_valid));
endmodule

// File: tb/sstk_unit_tb.sv
`timescale 1ns/1ps
module sstk_unit_tb;
  typedef struct packed {
    logic [2:0] op; logic [4:0] rd; logic w64, pm, en;
    logic [63:0] a, b, rdat; logic rerr, req, we;
    logic [63:0] raddr; logic [1:0] kind; logic [4:0] cause;
    logic [63:0] val; logic [3:0] tag;
  } vec_t;

  function automatic vec_t v(int op, int rd, int w, int pm, int en,
      logic [63:0] a, logic [63:0] b, logic [63:0] rdat, int rerr, int req, int we,
      logic [63:0] raddr, int kind, int cause, logic [63:0] val, int tag);
    vec_t r;
    r.op = 3'(op); r.rd = 5'(rd); r.w64 = 1'(w); r.pm = 1'(pm); r.en = 1'(en);
    r.a = a; r.b = b; r.rdat = rdat; r.rerr = 1'(rerr); r.req = 1'(req); r.we = 1'(we);
    r.raddr = raddr; r.kind = 2'(kind); r.cause = 5'(cause); r.val = val; r.tag = 4'(tag);
    return r;
  endfunction

  localparam int NV = 25;
  // kind: 0 nothing, 1 writeback, 2 exception
  localparam vec_t VEC [NV] = '{
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'h1000, 6),             // R6 read pointer
    v(0,0,1,0,1, 0,64'hAAAA0001,0, 0,1,1, 64'hFF8, 0,0,0, 2),   // R2 push 8-byte
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'hFF8, 2),
    v(1,0,1,0,1, 64'hAAAA0001,0,64'hAAAA0001, 0,1,0, 64'hFF8, 0,0,0, 3), // R3 pop match
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'h1000, 3),
    v(0,0,0,0,1, 0,64'h55,0, 0,1,1, 64'hFFC, 0,0,0, 1),         // R1 4-byte step
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'hFFC, 1),
    v(1,0,0,0,1, 64'h123,0,64'h999, 0,1,0, 64'hFFC, 2,18,3, 4), // R4 mismatch
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'hFFC, 4),
    v(1,0,1,0,1, 64'h55,0,0, 0,0,0, 0, 2,6,64'hFFC, 5),         // R5 misaligned pop
    v(1,0,0,0,1, 64'h55,0,64'h55, 1,1,0, 64'hFFC, 2,7,64'hFFC, 10), // R10 mem error
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'hFFC, 10),
    v(1,0,0,0,1, 64'hFFFFFFFF00000055,0,64'h55, 0,1,0, 64'hFFC, 0,0,0, 3), // R3 low-half compare
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'h1000, 3),
    v(2,0,1,0,1, 0,0,0, 0,0,0, 0, 2,2,0, 6),                    // R6 rd zero
    v(0,0,1,0,0, 0,1,0, 0,0,0, 0, 2,2,0, 7),                    // R7 disabled push
    v(2,5,1,0,0, 0,0,0, 0,0,0, 0, 2,2,0, 7),                    // R7 disabled read
    v(3,7,1,1,1, 64'h2000,5,0, 0,0,0, 0, 2,7,64'h2000, 8),      // R8 machine mode
    v(3,7,1,0,1, 64'h2004,5,64'h80000001, 0,1,1, 64'h2004, 1,0,64'hFFFFFFFF80000001, 9), // R9
    v(4,8,1,0,1, 64'h2008,6,64'h80000001, 0,1,1, 64'h2008, 1,0,64'h80000001, 9),
    v(4,8,0,0,1, 64'h2008,6,0, 0,0,0, 0, 2,2,0, 9),             // R9 dword at 32-bit
    v(3,7,1,0,1, 64'h2002,5,0, 0,0,0, 0, 2,6,64'h2002, 5),      // R5 misaligned swap
    v(3,7,1,0,0, 64'h2004,5,0, 0,0,0, 0, 2,2,0, 7),             // R7 swap disabled
    v(7,1,1,0,1, 0,0,0, 0,0,0, 0, 2,2,0, 7),                    // R7 bad op
    v(2,5,1,0,1, 0,0,0, 0,0,0, 0, 1,0,64'h1000, 10)
  };

  logic clk = 0, rst_n = 0;
  logic issue_valid = 0; logic [2:0] issue_op = 0; logic [4:0] issue_rd = 0;
  logic [63:0] op_a = 0, op_b = 0, ssp_wdata = 0, mem_resp_rdata = 0;
  logic wide_mode = 1, mach_mode = 0, bcfi_en = 1, ssp_wr = 0;
  logic mem_resp_valid = 0, mem_resp_err = 0;
  logic busy, mem_req_valid, mem_req_we, mem_req_swap, mem_req_dw, mem_req_ss;
  logic [63:0] mem_req_addr, mem_req_wdata, wb_data, exc_tval;
  logic wb_valid, exc_valid; logic [4:0] wb_rd, exc_cause;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sstk_unit u_dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_op(issue_op),
    .issue_rd(issue_rd), .op_a(op_a), .op_b(op_b), .wide_mode(wide_mode),
    .mach_mode(mach_mode), .bcfi_en(bcfi_en), .ssp_wr(ssp_wr), .ssp_wdata(ssp_wdata),
    .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
    .mem_req_swap(mem_req_swap), .mem_req_dw(mem_req_dw), .mem_req_ss(mem_req_ss),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_resp_valid(mem_resp_valid), .mem_resp_err(mem_resp_err),
    .mem_resp_rdata(mem_resp_rdata), .wb_valid(wb_valid), .wb_rd(wb_rd),
    .wb_data(wb_data), .exc_valid(exc_valid), .exc_cause(exc_cause), .exc_tval(exc_tval));

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [4:0] rd, input logic [63:0] a,
                       input logic [63:0] b);
    @(negedge clk);
    issue_valid = 1; issue_op = op; issue_rd = rd; op_a = a; op_b = b;
    @(negedge clk);
    issue_valid = 0;
  endtask

  task automatic respond(input logic [63:0] d, input logic e);
    mem_resp_valid = 1; mem_resp_rdata = d; mem_resp_err = e;
    @(negedge clk);
    mem_resp_valid = 0; mem_resp_err = 0;
  endtask

  task automatic rdptr_chk(input string req, input logic [63:0] exp);
    wide_mode = 1; bcfi_en = 1; mach_mode = 0;
    issue(3'd2, 5'd4, 0, 0);
    chk(wb_valid && wb_rd == 5'd4 && wb_data == exp, req, "pointer", wb_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !mem_req_valid && !wb_valid && !exc_valid, "R11", "reset idle",
        {60'd0, busy, mem_req_valid, wb_valid, exc_valid}, 0);
    rst_n = 1;
    @(negedge clk);
    ssp_wr = 1; ssp_wdata = 64'h1000;
    @(negedge clk);
    ssp_wr = 0;

    for (int i = 0; i < NV; i++) begin
      string tg;
      tg = $sformatf("R%0d", VEC[i].tag);
      wide_mode = VEC[i].w64; mach_mode = VEC[i].pm; bcfi_en = VEC[i].en;
      issue(VEC[i].op, VEC[i].rd, VEC[i].a, VEC[i].b);
      if (VEC[i].req) begin
        chk(mem_req_valid && mem_req_ss && busy, tg, "request tag", {61'd0, mem_req_valid, mem_req_ss, busy}, 7);
        chk(mem_req_addr == VEC[i].raddr, tg, "request addr", mem_req_addr, VEC[i].raddr);
        chk(mem_req_we == VEC[i].we, tg, "request we", {63'd0, mem_req_we}, {63'd0, VEC[i].we});
        if (VEC[i].we)
          chk(mem_req_wdata == VEC[i].b, tg, "store data", mem_req_wdata, VEC[i].b);
        respond(VEC[i].rdat, VEC[i].rerr);
      end else begin
        chk(!mem_req_valid, tg, "no request", {63'd0, mem_req_valid}, 0);
      end
      case (VEC[i].kind)
        2'd0: chk(!wb_valid && !exc_valid, tg, "quiet", {62'd0, wb_valid, exc_valid}, 0);
        2'd1: chk(wb_valid && !exc_valid && wb_rd == VEC[i].rd && wb_data == VEC[i].val,
                  tg, "writeback", wb_data, VEC[i].val);
        default: chk(exc_valid && !wb_valid && exc_cause == VEC[i].cause && exc_tval == VEC[i].val,
                     tg, "exception", {exc_cause, exc_tval[58:0]}, {VEC[i].cause, VEC[i].val[58:0]});
      endcase
    end

    // R11 / R12: issue and pointer write during busy are ignored
    wide_mode = 1; bcfi_en = 1; mach_mode = 0;
    issue(3'd0, 5'd0, 0, 64'h77);
    chk(busy && mem_req_addr == 64'hFF8, "R11", "busy push", mem_req_addr, 64'hFF8);
    issue_valid = 1; issue_op = 3'd2; issue_rd = 5'd3; ssp_wr = 1; ssp_wdata = 64'h5000;
    @(negedge clk);
    issue_valid = 0; ssp_wr = 0;
    chk(!wb_valid && busy, "R11", "issue while busy", {62'd0, wb_valid, busy}, 1);
    respond(64'h0, 1'b0);
    chk(!busy, "R11", "busy cleared", {63'd0, busy}, 0);
    rdptr_chk("R12", 64'hFF8);
    @(negedge clk);
    ssp_wr = 1; ssp_wdata = 64'h3000;
    @(negedge clk);
    ssp_wr = 0;
    rdptr_chk("R12", 64'h3000);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule